// File: doc/BRIEF.md
# Instruction Prefix and Operand-Extension Unit

This block holds a one-shot prefix for a small 16-bit processor core. An executing instruction that writes the prefix supplies a 16-bit value and a 3-bit selection code. Both are captured on that instruction's execution edge. They then shape the operands of the next instruction that executes, and clear themselves once that instruction has executed.

Three operand outputs are formed from the stored state and from the current instruction's fields. The first is a 16-bit immediate: the prefix low byte on top and the 8-bit literal below it. The second is a 5-bit source register number. The third is a 5-bit destination register number. The stored 16-bit value can also be read back. An execution cycle is marked by an exec-enable strobe. When the strobe is low, nothing expires and nothing is written.

Top module: `opx_prefix_unit`

## Requirements
- R1: A synchronous active-low reset clears the stored value to 0000h and the selection code to 0. Reset takes precedence over a write in the same cycle.
- R2: On a clock edge with `exec_en`=1 and `pfx_wr`=1, `pfx_wdata` and `pfx_sel` are stored. `rd_data` shows the whole stored 16-bit value after that edge.
- R3: `imm_out` equals {stored bits 7:0, `lit_in`}. Stored bits 15:8 never reach it. With no active prefix the high byte is 00h.
- R4: `src_idx` equals {selection bit 0, `src_fld`}. Selection bit 0 = 0 gives sources 0h–Fh, and 1 gives sources 10h–1Fh.
- R5: `dst_idx` equals {selection bits 2:1, `dst_fld`}. The codes 00, 01, 10 and 11 select destinations 0h–7h, 8h–Fh, 10h–17h and 18h–1Fh.
- R6: On a clock edge with `exec_en`=1 and `pfx_wr`=0, the value and the selection both return to 0, without any write.
- R7: While `exec_en`=0, the value and the selection hold across edges. A `pfx_wr` pulse with `exec_en`=0 is ignored.
- R8: When the instruction that consumes a prefix also writes one, the new value and selection are loaded instead of cleared. They apply to the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_en | input | 1 | High when the current instruction executes on this edge |
| pfx_wr | input | 1 | Current instruction writes the prefix |
| pfx_sel | input | 3 | Write index: bit 0 picks the source range, bits 2:1 pick the destination range |
| pfx_wdata | input | 16 | Value written to the prefix |
| lit_in | input | 8 | 8-bit literal of the current instruction |
| src_fld | input | 4 | 4-bit source field of the current instruction |
| dst_fld | input | 3 | 3-bit destination field of the current instruction |
| rd_data | output | 16 | Stored prefix value |
| imm_out | output | 16 | Extended immediate |
| src_idx | output | 5 | Extended source register number |
| dst_idx | output | 5 | Extended destination register number |

## Verification
A write or an expiry changes the state on the edge where it is applied. The three operand outputs and `rd_data` are combinational from that state, so their effect is due in the cycle that follows the edge. Operand outputs follow the current instruction fields with no delay. The bench drives each vector on the falling edge and samples 2 ns later, before the next rising edge. Each vector's expected values therefore come from the state left by the earlier vectors, combined with that vector's own fields.

// File: rtl/opx_pkg.sv
// Package: default widths shared by the prefix unit and its submodules.
// Assumes the literal is no wider than the prefix value.
package opx_pkg;
    localparam int unsigned PFX_W     = 16;  // stored prefix value width
    localparam int unsigned LIT_W     = 8;   // instruction literal width
    localparam int unsigned SEL_W     = 3;   // write index width
    localparam int unsigned SRC_FLD_W = 4;   // instruction source field width
    localparam int unsigned DST_FLD_W = 3;   // instruction destination field width
endpackage

// File: rtl/opx_store.sv
// Module: opx_store
// Holds the one-shot prefix value and selection code. A write is taken only
// on an executing edge. Any other executing edge clears both, and edges
// without execution leave both untouched.
// Assumes a synchronous active-low reset.
module opx_store #(
    parameter int unsigned PFX_W = opx_pkg::PFX_W,
    parameter int unsigned SEL_W = opx_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_en,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [PFX_W-1:0] wr_val,
    output logic [PFX_W-1:0] cur_val,
    output logic [SEL_W-1:0] cur_sel
);
    logic [PFX_W-1:0] val_q;
    logic [SEL_W-1:0] sel_q;

    // Update: a write beats expiry; non-executing edges hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            sel_q <= '0;
        end else if (exec_en) begin
            if (wr_en) begin
                val_q <= wr_val;
                sel_q <= wr_sel;
            end else begin
                val_q <= '0;
                sel_q <= '0;
            end
        end
    end

    assign cur_val = val_q;
    assign cur_sel = sel_q;

    // R1: reset leaves a clean state
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (val_q == '0 && sel_q == '0));

    // R2 / R8: an executing write is captured
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && wr_en) |=> (val_q == $past(wr_val) && sel_q == $past(wr_sel)));

    // R6: an executing edge without a write expires the prefix
    p_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !wr_en) |=> (val_q == '0 && sel_q == '0));

    // R7: nothing moves without execution
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_en && rst_n) |=> ($stable(val_q) && $stable(sel_q)));
endmodule

// File: rtl/opx_form.sv
// Module: opx_form
// Builds the extended operands from the live prefix state and the current
// instruction fields. Purely combinational.
// Assumes the low selection bit picks the source range and the upper
// selection bits pick the destination range.
module opx_form #(
    parameter int unsigned PFX_W     = opx_pkg::PFX_W,
    parameter int unsigned LIT_W     = opx_pkg::LIT_W,
    parameter int unsigned SEL_W     = opx_pkg::SEL_W,
    parameter int unsigned SRC_FLD_W = opx_pkg::SRC_FLD_W,
    parameter int unsigned DST_FLD_W = opx_pkg::DST_FLD_W,
    localparam int unsigned IMM_W    = 2 * LIT_W,
    localparam int unsigned SRC_W    = SRC_FLD_W + 1,
    localparam int unsigned DST_W    = DST_FLD_W + SEL_W - 1
) (
    input  logic [PFX_W-1:0]     pfx_val,
    input  logic [SEL_W-1:0]     pfx_sel,
    input  logic [LIT_W-1:0]     lit,
    input  logic [SRC_FLD_W-1:0] src_f,
    input  logic [DST_FLD_W-1:0] dst_f,
    output logic [IMM_W-1:0]     imm,
    output logic [SRC_W-1:0]     src_n,
    output logic [DST_W-1:0]     dst_n
);
    // Operand join: only the low literal-width slice of the prefix is used.
    always_comb begin
        imm   = {pfx_val[LIT_W-1:0], lit};
        src_n = {pfx_sel[0], src_f};
        dst_n = {pfx_sel[SEL_W-1:1], dst_f};
    end
endmodule

// File: rtl/opx_prefix_unit.sv
// Module: opx_prefix_unit (top)
// One-shot instruction prefix. It stores a value and a range selection that
// apply to the next executing instruction only, and forms the extended
// immediate and register numbers for that instruction.
// Assumes exec_en marks each instruction's execution edge.
module opx_prefix_unit #(
    parameter int unsigned PFX_W     = opx_pkg::PFX_W,
    parameter int unsigned LIT_W     = opx_pkg::LIT_W,
    parameter int unsigned SEL_W     = opx_pkg::SEL_W,
    parameter int unsigned SRC_FLD_W = opx_pkg::SRC_FLD_W,
    parameter int unsigned DST_FLD_W = opx_pkg::DST_FLD_W,
    localparam int unsigned IMM_W    = 2 * LIT_W,
    localparam int unsigned SRC_W    = SRC_FLD_W + 1,
    localparam int unsigned DST_W    = DST_FLD_W + SEL_W - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exec_en,
    input  logic                 pfx_wr,
    input  logic [SEL_W-1:0]     pfx_sel,
    input  logic [PFX_W-1:0]     pfx_wdata,
    input  logic [LIT_W-1:0]     lit_in,
    input  logic [SRC_FLD_W-1:0] src_fld,
    input  logic [DST_FLD_W-1:0] dst_fld,
    output logic [PFX_W-1:0]     rd_data,
    output logic [IMM_W-1:0]     imm_out,
    output logic [SRC_W-1:0]     src_idx,
    output logic [DST_W-1:0]     dst_idx
);
    logic [PFX_W-1:0] live_val;
    logic [SEL_W-1:0] live_sel;

    opx_store #(.PFX_W(PFX_W), .SEL_W(SEL_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec_en (exec_en),
        .wr_en   (pfx_wr),
        .wr_sel  (pfx_sel),
        .wr_val  (pfx_wdata),
        .cur_val (live_val),
        .cur_sel (live_sel)
    );

    opx_form #(
        .PFX_W(PFX_W), .LIT_W(LIT_W), .SEL_W(SEL_W),
        .SRC_FLD_W(SRC_FLD_W), .DST_FLD_W(DST_FLD_W)
    ) u_form (
        .pfx_val (live_val),
        .pfx_sel (live_sel),
        .lit     (lit_in),
        .src_f   (src_fld),
        .dst_f   (dst_fld),
        .imm     (imm_out),
        .src_n   (src_idx),
        .dst_n   (dst_idx)
    );

    assign rd_data = live_val;

    // R3: an empty prefix gives a zero-extended literal
    p_imm_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data == '0) |-> (imm_out[IMM_W-1:LIT_W] == '0));

    // R3: the immediate's low half always follows the literal
    p_imm_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        imm_out[LIT_W-1:0] == lit_in);
endmodule

// File: tb/opx_prefix_unit_tb.sv
module opx_prefix_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic        pfx_wr = 1'b0;
    logic [2:0]  pfx_sel = '0;
    logic [15:0] pfx_wdata = '0;
    logic [7:0]  lit_in = '0;
    logic [3:0]  src_fld = '0;
    logic [2:0]  dst_fld = '0;
    logic [15:0] rd_data;
    logic [15:0] imm_out;
    logic [4:0]  src_idx;
    logic [4:0]  dst_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    opx_prefix_unit u_dut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .pfx_wr(pfx_wr),
        .pfx_sel(pfx_sel), .pfx_wdata(pfx_wdata), .lit_in(lit_in),
        .src_fld(src_fld), .dst_fld(dst_fld), .rd_data(rd_data),
        .imm_out(imm_out), .src_idx(src_idx), .dst_idx(dst_idx)
    );

    typedef struct packed {
        logic        ex;
        logic        wr;
        logic [2:0]  sel;
        logic [15:0] wd;
        logic [7:0]  lit;
        logic [3:0]  sf;
        logic [2:0]  df;
        logic [15:0] e_rd;
        logic [15:0] e_imm;
        logic [4:0]  e_src;
        logic [4:0]  e_dst;
    } vec_t;

    // Expected values use the state left by earlier rows plus this row's fields.
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,3'd3,16'hA5C3,8'h12,4'h5,3'd6,16'h0000,16'h0012,5'h05,5'h06}, // R1 reset state; R2 write
        '{1'b0,1'b0,3'd0,16'h0000,8'h34,4'h2,3'd1,16'hA5C3,16'hC334,5'h12,5'h09}, // R2 R4 R5 R7
        '{1'b0,1'b1,3'd7,16'hFFFF,8'h00,4'hF,3'd7,16'hA5C3,16'hC300,5'h1F,5'h0F}, // R7 write ignored
        '{1'b1,1'b0,3'd0,16'h0000,8'h56,4'h0,3'd0,16'hA5C3,16'hC356,5'h10,5'h08}, // R7 held; consumer
        '{1'b1,1'b0,3'd0,16'h0000,8'h78,4'h9,3'd3,16'h0000,16'h0078,5'h09,5'h03}, // R6 expired
        '{1'b1,1'b1,3'd4,16'h12FE,8'hAB,4'h1,3'd2,16'h0000,16'h00AB,5'h01,5'h02}, // write sel 4
        '{1'b1,1'b1,3'd5,16'h0081,8'hCD,4'h3,3'd4,16'h12FE,16'hFECD,5'h03,5'h14}, // R8 consume + rewrite
        '{1'b1,1'b0,3'd0,16'h0000,8'hEF,4'hA,3'd5,16'h0081,16'h81EF,5'h1A,5'h15}, // R8 new prefix applies
        '{1'b0,1'b0,3'd0,16'h0000,8'h01,4'hB,3'd1,16'h0000,16'h0001,5'h0B,5'h01}, // R6 cleared
        '{1'b1,1'b1,3'd6,16'hFF00,8'h02,4'hC,3'd7,16'h0000,16'h0002,5'h0C,5'h07}, // write sel 6
        '{1'b1,1'b0,3'd0,16'h0000,8'h99,4'h4,3'd0,16'hFF00,16'h0099,5'h04,5'h18}, // R3 upper byte unused
        '{1'b1,1'b1,3'd1,16'h0007,8'h10,4'h6,3'd3,16'h0000,16'h0010,5'h06,5'h03}, // write sel 1
        '{1'b0,1'b0,3'd0,16'h0000,8'h20,4'h7,3'd2,16'h0007,16'h0720,5'h17,5'h02}, // R7 idle
        '{1'b1,1'b0,3'd0,16'h0000,8'h30,4'h8,3'd6,16'h0007,16'h0730,5'h18,5'h06}, // R4 consume
        '{1'b0,1'b0,3'd0,16'h0000,8'h40,4'h1,3'd1,16'h0000,16'h0040,5'h01,5'h01}  // R6 cleared
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic ex, input logic wr, input logic [2:0] sel,
                         input logic [15:0] wd, input logic [7:0] lit,
                         input logic [3:0] sf, input logic [2:0] df);
        exec_en = ex; pfx_wr = wr; pfx_sel = sel; pfx_wdata = wd;
        lit_in = lit; src_fld = sf; dst_fld = df;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive on the falling edge, sample 2 ns later.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ex, VECS[i].wr, VECS[i].sel, VECS[i].wd,
                  VECS[i].lit, VECS[i].sf, VECS[i].df);
            #2;
            chk($sformatf("R2/R6/R7 rd_data row %0d", i), rd_data, VECS[i].e_rd);
            chk($sformatf("R3 imm_out row %0d", i), imm_out, VECS[i].e_imm);
            chk($sformatf("R4 src_idx row %0d", i), {11'd0, src_idx}, {11'd0, VECS[i].e_src});
            chk($sformatf("R5 dst_idx row %0d", i), {11'd0, dst_idx}, {11'd0, VECS[i].e_dst});
            @(negedge clk);
        end

        // Directed R1: reset while a prefix is live.
        drive(1'b1, 1'b1, 3'd7, 16'hBEEF, 8'h11, 4'h2, 3'd3);
        @(negedge clk);
        drive(1'b0, 1'b0, 3'd0, 16'h0000, 8'h11, 4'h2, 3'd3);
        #2;
        chk("R2 rd_data before reset", rd_data, 16'hBEEF);
        chk("R4 src_idx before reset", {11'd0, src_idx}, 16'h0012);
        chk("R5 dst_idx before reset", {11'd0, dst_idx}, 16'h001B);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1 rd_data after reset", rd_data, 16'h0000);
        chk("R1 imm_out after reset", imm_out, 16'h0011);
        chk("R1 src_idx after reset", {11'd0, src_idx}, 16'h0002);
        chk("R1 dst_idx after reset", {11'd0, dst_idx}, 16'h0003);

        // Directed R1: reset beats an executing write on the same edge.
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 3'd7, 16'h1234, 8'h11, 4'h2, 3'd3);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 3'd0, 16'h0000, 8'h11, 4'h2, 3'd3);
        #2;
        chk("R1 rd_data reset over write", rd_data, 16'h0000);
        chk("R1 src_idx reset over write", {11'd0, src_idx}, 16'h0002);
        chk("R1 dst_idx reset over write", {11'd0, dst_idx}, 16'h0003);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule